// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Timing

This block is a single-direction 36-bit FIFO whose write side and read side each run on their own free-running clock. The two clocks may be unrelated or may be one and the same net. The write pointer crosses into the read domain, and the read pointer into the write domain, as Gray code through multi-flop synchronizers. Each status flag is therefore produced in the domain of the port that consumes it, and it releases a few cycles late, which errs on the safe side.

A mode input, sampled while reset is high, selects one of two read timings. In standard timing a read request moves the oldest word onto the output one clock later, and the flags report empty and full. In fall-through timing the oldest word is placed on the output with no request, a read request pops it, and the flags report output-ready and input-ready. Almost-empty and almost-full thresholds are either picked from three presets or loaded through the write data bus just after reset.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, both pointers are zero, `rd_almost_empty` is 1 and `wr_almost_full` is 0. `rd_flag` is 1 in standard timing (empty) and 0 in fall-through timing (not ready). `wr_flag` is 0 in standard timing (not full) and 1 in fall-through timing (ready).
- R2: A write request is `wr_cs`=1, `wr_dir`=1, `wr_en`=1. It is accepted when the FIFO is not full, and words leave in the order they were accepted.
- R3: Once DEPTH words are stored, the full state shows on `wr_flag` (1 in standard timing, 0 in fall-through timing). A write request made while full is dropped, and the write pointer and the stored data stay unchanged.
- R4: A read request made while `rd_flag` shows no data (1 in standard timing, 0 in fall-through timing) leaves the read pointer and the output queue unchanged.
- R5: In standard timing, a read request is `rd_cs`=1, `rd_dir`=0, `rd_en`=1. When it is made with `rd_flag`=0, the read pointer advances and the popped word is on `rd_data` from the next `rd_clk` edge until the next accepted read.
- R6: In fall-through timing, the oldest word appears on `rd_data` with `rd_flag`=1 and no read request. It holds while no request is made, and a request pops it.
- R7: A request with any of its chip-select, direction or enable qualifiers at the wrong value has no effect on either side.
- R8: `fwft_sel` (1 = fall-through) is captured only while `rst` is high. Changing it later does not change flag behaviour.
- R9: `ofs_sel` is captured during reset. 01, 10 and 11 set both offsets to 8, 16 and 64. `rd_almost_empty` is 1 when the readable word count (including a word held on the output in fall-through timing) is at most the empty offset. `wr_almost_full` is 1 when the stored word count is at least DEPTH minus the full offset.
- R10: With `ofs_sel`=00, the first two write requests after reset load the empty offset and then the full offset from the low log2(DEPTH) bits of `wr_data`. These two words are not stored.
- R11: When both ports share one clock, a read and a write on the same edge both complete and no word is lost or duplicated.
- R12: Each synchronized pointer, kept in Gray code, changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held over edges of both clocks |
| fwft_sel | input | 1 | Timing select captured at reset, 1 = fall-through |
| ofs_sel | input | 2 | Offset select captured at reset |
| wr_cs | input | 1 | Write port select |
| wr_dir | input | 1 | Write port direction, 1 = write |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Write data, also carries offsets after reset |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| wr_almost_full | output | 1 | Almost-full flag, write domain |
| rd_cs | input | 1 | Read port select |
| rd_dir | input | 1 | Read port direction, 0 = read |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Read data |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| rd_almost_empty | output | 1 | Almost-empty flag, read domain |

## Verification
The bench builds the block with DEPTH=256, the smallest supported size, and SYNC_STAGES=2. At that size a complete fill to full, writes dropped at the limit, and a full drain all fit in a few hundred cycles. Both ports are driven from one clock, which makes the shared-clock case of simultaneous read and write directly observable. It also turns the flag lag from the synchronizers into a fixed number of cycles, so the bench can let the flags settle and then compare them against its own word count. Resetting again between scenarios covers both timing modes and all offset choices, including loaded offsets.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [1:0] {
    OFS_LOADED = 2'b00,
    OFS_SMALL  = 2'b01,
    OFS_MID    = 2'b10,
    OFS_LARGE  = 2'b11
  } ofs_mode_e;

  function automatic logic [15:0] preset_offset(input logic [1:0] sel);
    case (sel)
      OFS_SMALL: preset_offset = 16'd8;
      OFS_MID:   preset_offset = 16'd16;
      OFS_LARGE: preset_offset = 16'd64;
      default:   preset_offset = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwft_in,
  input  logic [1:0]    ofs_in,
  input  logic          req,
  input  logic [AW-1:0] ofs_data,
  input  logic [AW:0]   rgray_sync,
  output logic          we,
  output logic [AW:0]   wptr,
  output logic [AW:0]   wgray,
  output logic          flag,
  output logic          almost_full,
  output logic [AW-1:0] ae_off
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(2 ** AW);

  logic          mode_q, full_q, flag_q, af_q;
  logic [1:0]    prog_q;
  logic [AW-1:0] ae_off_q, af_off_q;
  logic [PW-1:0] wptr_q, wgray_q;
  logic [PW-1:0] rbin, wptr_n, level_n;
  logic          prog_active, do_wr, full_n, af_n;

  always_comb begin
    rbin[PW-1] = rgray_sync[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync[i];
  end

  assign prog_active = (prog_q != 2'd0);
  assign do_wr       = req & ~full_q & ~prog_active;
  assign wptr_n      = wptr_q + PW'(do_wr);
  assign level_n     = wptr_n - rbin;
  assign full_n      = (level_n == FULL_LVL);
  assign af_n        = (level_n >= (FULL_LVL - {1'b0, af_off_q}));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= fwft_in;
      prog_q   <= (ofs_in == OFS_LOADED) ? 2'd2 : 2'd0;
      ae_off_q <= AW'(preset_offset(ofs_in));
      af_off_q <= AW'(preset_offset(ofs_in));
      wptr_q   <= '0;
      wgray_q  <= '0;
      full_q   <= 1'b0;
      flag_q   <= fwft_in;
      af_q     <= 1'b0;
    end else begin
      wptr_q  <= wptr_n;
      wgray_q <= wptr_n ^ (wptr_n >> 1);
      full_q  <= full_n;
      flag_q  <= mode_q ? ~full_n : full_n;
      af_q    <= af_n;
      if (prog_active && req) begin
        if (prog_q == 2'd2) ae_off_q <= ofs_data;
        else                af_off_q <= ofs_data;
        prog_q <= prog_q - 2'd1;
      end
    end
  end

  assign we          = do_wr;
  assign wptr        = wptr_q;
  assign wgray       = wgray_q;
  assign flag        = flag_q;
  assign almost_full = af_q;
  assign ae_off      = ae_off_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwft_in,
  input  logic          req,
  input  logic [AW:0]   wgray_sync,
  input  logic [AW-1:0] ae_off,
  output logic          re,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic          flag,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic          mode_q, memempty_q, ov_q, flag_q, ae_q;
  logic [PW-1:0] rptr_q, rgray_q;
  logic [PW-1:0] wbin, rptr_n, level_n;
  logic          load, ov_n, memempty_n;

  always_comb begin
    wbin[PW-1] = wgray_sync[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync[i];
  end

  // Fall-through keeps the output register filled; standard loads on request.
  assign load       = mode_q ? (~memempty_q & (~ov_q | req)) : (req & ~memempty_q);
  assign ov_n       = mode_q & (load | (ov_q & ~req));
  assign rptr_n     = rptr_q + PW'(load);
  assign memempty_n = (rptr_n == wbin);
  assign level_n    = wbin - rptr_n + PW'(ov_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= fwft_in;
      memempty_q <= 1'b1;
      ov_q       <= 1'b0;
      flag_q     <= ~fwft_in;
      ae_q       <= 1'b1;
      rptr_q     <= '0;
      rgray_q    <= '0;
    end else begin
      memempty_q <= memempty_n;
      ov_q       <= ov_n;
      flag_q     <= mode_q ? ov_n : memempty_n;
      ae_q       <= (level_n <= {1'b0, ae_off});
      rptr_q     <= rptr_n;
      rgray_q    <= rptr_n ^ (rptr_n >> 1);
    end
  end

  assign re           = load;
  assign rptr         = rptr_q;
  assign rgray        = rgray_q;
  assign flag         = flag_q;
  assign almost_empty = ae_q;
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DW          = 36,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          fwft_sel,
  input  logic [1:0]    ofs_sel,
  input  logic          wr_cs,
  input  logic          wr_dir,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_flag,
  output logic          wr_almost_full,
  input  logic          rd_cs,
  input  logic          rd_dir,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          rd_almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_req, rd_req, we, re;
  logic [PW-1:0] wptr, rptr, wgray, rgray, wgray_rs, rgray_ws;
  logic [AW-1:0] ae_off;

  assign wr_req = wr_cs & wr_dir & wr_en;
  assign rd_req = rd_cs & ~rd_dir & rd_en;

  dcf_wr_ctrl #(.AW(AW)) wr_ctrl_i (
    .clk        (wr_clk),
    .rst        (rst),
    .fwft_in    (fwft_sel),
    .ofs_in     (ofs_sel),
    .req        (wr_req),
    .ofs_data   (wr_data[AW-1:0]),
    .rgray_sync (rgray_ws),
    .we         (we),
    .wptr       (wptr),
    .wgray      (wgray),
    .flag       (wr_flag),
    .almost_full(wr_almost_full),
    .ae_off     (ae_off)
  );

  dcf_rd_ctrl #(.AW(AW)) rd_ctrl_i (
    .clk         (rd_clk),
    .rst         (rst),
    .fwft_in     (fwft_sel),
    .req         (rd_req),
    .wgray_sync  (wgray_rs),
    .ae_off      (ae_off),
    .re          (re),
    .rptr        (rptr),
    .rgray       (rgray),
    .flag        (rd_flag),
    .almost_empty(rd_almost_empty)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_sync_i (
    .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_rs)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_sync_i (
    .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_ws)
  );

  dcf_ram #(.DW(DW), .AW(AW)) ram_i (
    .wclk (wr_clk),
    .we   (we),
    .waddr(wptr[AW-1:0]),
    .wdata(wr_data),
    .rclk (rd_clk),
    .re   (re),
    .raddr(rptr[AW-1:0]),
    .rdata(rd_data)
  );
endmodule

// File: rtl/dual_clock_fifo_chk.sv
module dual_clock_fifo_chk #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          fwft_sel,
  input logic          wr_cs,
  input logic          wr_dir,
  input logic          wr_en,
  input logic          rd_cs,
  input logic          rd_dir,
  input logic          rd_en,
  input logic          wr_flag,
  input logic          rd_flag,
  input logic          rd_almost_empty,
  input logic [AW:0]   wptr,
  input logic [AW:0]   rptr,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] rd_data
);
  logic mode_w, mode_r;
  logic wr_req, rd_req, wr_full;

  always_ff @(posedge wr_clk) if (rst) mode_w <= fwft_sel;
  always_ff @(posedge rd_clk) if (rst) mode_r <= fwft_sel;

  assign wr_req  = wr_cs & wr_dir & wr_en;
  assign rd_req  = rd_cs & ~rd_dir & rd_en;
  assign wr_full = mode_w ? ~wr_flag : wr_flag;

  p_wptr_clear_r1: assert property (@(posedge wr_clk) rst |=> (wptr == '0));
  p_rptr_clear_r1: assert property (@(posedge rd_clk) rst |=> (rptr == '0) && rd_almost_empty);

  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_req && wr_full) |=> $stable(wptr));

  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (rst)
    (!mode_r && rd_req && rd_flag) |=> $stable(rptr));

  p_std_advance_r5: assert property (@(posedge rd_clk) disable iff (rst)
    (!mode_r && rd_req && !rd_flag) |=> (rptr == $past(rptr) + 1'b1));

  p_fwft_hold_r6: assert property (@(posedge rd_clk) disable iff (rst)
    (mode_r && rd_flag && !rd_req) |=> $stable(rd_data) && rd_flag);

  p_wgray_step_r12: assert property (@(posedge wr_clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_rgray_step_r12: assert property (@(posedge rd_clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.AW(AW), .DW(DW)) chk_i (
  .wr_clk         (wr_clk),
  .rd_clk         (rd_clk),
  .rst            (rst),
  .fwft_sel       (fwft_sel),
  .wr_cs          (wr_cs),
  .wr_dir         (wr_dir),
  .wr_en          (wr_en),
  .rd_cs          (rd_cs),
  .rd_dir         (rd_dir),
  .rd_en          (rd_en),
  .wr_flag        (wr_flag),
  .rd_flag        (rd_flag),
  .rd_almost_empty(rd_almost_empty),
  .wptr           (wptr),
  .rptr           (rptr),
  .wgray          (wgray),
  .rgray          (rgray),
  .rd_data        (rd_data)
);

// File: tb/dual_clock_fifo_tb_top.sv
module dual_clock_fifo_tb_top;
  localparam int DW    = 36;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fwft_sel = 1'b0;
  logic [1:0]    ofs_sel = 2'b01;
  logic          wr_cs = 1'b0, wr_dir = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_cs = 1'b0, rd_dir = 1'b1, rd_en = 1'b0;
  logic          wr_flag, wr_almost_full, rd_flag, rd_almost_empty;
  logic [DW-1:0] rd_data;

  int            checks = 0;
  int            fails  = 0;
  int            seq    = 0;
  bit            tb_fwft = 1'b0;
  bit            pend    = 1'b0;
  logic [DW-1:0] sb[$];

  always #2 clk = ~clk;

  dual_clock_fifo #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .fwft_sel(fwft_sel), .ofs_sel(ofs_sel),
    .wr_cs(wr_cs), .wr_dir(wr_dir), .wr_en(wr_en), .wr_data(wr_data),
    .wr_flag(wr_flag), .wr_almost_full(wr_almost_full),
    .rd_cs(rd_cs), .rd_dir(rd_dir), .rd_en(rd_en), .rd_data(rd_data),
    .rd_flag(rd_flag), .rd_almost_empty(rd_almost_empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as the design delivers words.
  always @(negedge clk) begin
    logic [DW-1:0] exp_w;
    if (pend) begin
      pend = 1'b0;
      if (sb.size() == 0) chk(1'b0, "R4 word delivered with nothing stored", rd_data, '0);
      else begin
        exp_w = sb.pop_front();
        chk(rd_data == exp_w, "R2 R5 standard read order", rd_data, exp_w);
      end
    end
    if (!rst && rd_cs && !rd_dir && rd_en) begin
      if (!tb_fwft) begin
        if (!rd_flag) pend = 1'b1;
      end else if (rd_flag) begin
        if (sb.size() == 0) chk(1'b0, "R4 ready with nothing stored", rd_data, '0);
        else begin
          exp_w = sb.pop_front();
          chk(rd_data == exp_w, "R2 R6 fall-through read order", rd_data, exp_w);
        end
      end
    end
  end

  // Driver: pushes each word it expects the design to accept.
  task automatic wr_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_cs = 1'b1; wr_dir = 1'b1; wr_en = 1'b1;
      wr_data = {4'h5, 32'(seq)};
      seq++;
      @(negedge clk);
      if (tb_fwft ? wr_flag : !wr_flag) sb.push_back(wr_data);
    end
    @(posedge clk); #1;
    wr_cs = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr_raw(input bit cs, input bit dir, input bit en, input logic [DW-1:0] d, input int n);
    @(posedge clk); #1;
    wr_cs = cs; wr_dir = dir; wr_en = en; wr_data = d;
    repeat (n) @(posedge clk);
    #1;
    wr_cs = 1'b0; wr_dir = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_set(input bit cs, input bit dir, input bit en);
    @(posedge clk); #1;
    rd_cs = cs; rd_dir = dir; rd_en = en;
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    int t = 0;
    rd_set(1'b1, 1'b0, 1'b1);
    while ((sb.size() != 0 || pend) && t < 3000) begin
      @(posedge clk);
      t++;
    end
    if (t >= 3000) chk(1'b0, "R2 drain timed out", DW'(sb.size()), '0);
    rd_set(1'b0, 1'b1, 1'b0);
  endtask

  task automatic do_reset(input bit mode, input logic [1:0] sel);
    @(posedge clk); #1;
    rst = 1'b1; fwft_sel = mode; ofs_sel = sel; tb_fwft = mode;
    wr_cs = 0; wr_en = 0; rd_cs = 0; rd_en = 0; rd_dir = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    sb.delete();
    pend = 1'b0;
    fwft_sel = ~mode;
    ofs_sel  = ~sel;
    @(negedge clk);
    chk(rd_flag == !mode, "R1 read flag after reset", DW'(rd_flag), DW'(!mode));
    chk(wr_flag == mode, "R1 write flag after reset", DW'(wr_flag), DW'(mode));
    chk(rd_almost_empty == 1'b1, "R1 almost-empty after reset", DW'(rd_almost_empty), 1);
    chk(wr_almost_full == 1'b0, "R1 almost-full after reset", DW'(wr_almost_full), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_flag == !mode && wr_flag == mode, "R8 mode held after reset",
        DW'({rd_flag, wr_flag}), DW'({!mode, mode}));
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=0", sb.size());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // Standard timing, preset offset 8
    do_reset(1'b0, 2'b01);
    wr_raw(1'b0, 1'b1, 1'b1, 36'hBAD, 3);
    wr_raw(1'b1, 1'b0, 1'b1, 36'hBAD, 3);
    wr_raw(1'b1, 1'b1, 1'b0, 36'hBAD, 3);
    settle();
    chk(rd_flag == 1'b1, "R7 unqualified writes ignored", DW'(rd_flag), 1);
    rd_set(1'b1, 1'b0, 1'b1);
    repeat (5) @(posedge clk);
    rd_set(1'b0, 1'b1, 1'b0);
    wr_burst(8);
    settle();
    chk(rd_almost_empty == 1'b1, "R9 almost-empty at 8 words", DW'(rd_almost_empty), 1);
    wr_burst(1);
    settle();
    chk(rd_almost_empty == 1'b0, "R9 almost-empty clear at 9 words", DW'(rd_almost_empty), 0);
    wr_burst(238);
    settle();
    chk(wr_almost_full == 1'b0, "R9 almost-full clear at 247 words", DW'(wr_almost_full), 0);
    wr_burst(1);
    settle();
    chk(wr_almost_full == 1'b1, "R9 almost-full at 248 words", DW'(wr_almost_full), 1);
    wr_burst(8);
    settle();
    chk(wr_flag == 1'b1, "R3 full after DEPTH words", DW'(wr_flag), 1);
    chk(sb.size() == DEPTH, "R3 accepted word count", DW'(sb.size()), DW'(DEPTH));
    wr_burst(3);
    rd_set(1'b1, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    rd_set(1'b0, 1'b1, 1'b0);
    settle();
    chk(wr_flag == 1'b1, "R7 wrong-direction read ignored", DW'(wr_flag), 1);
    drain();
    settle();
    chk(rd_flag == 1'b1, "R5 empty after drain", DW'(rd_flag), 1);
    chk(rd_almost_empty == 1'b1, "R9 almost-empty after drain", DW'(rd_almost_empty), 1);
    wr_burst(2);
    drain();

    // Standard timing, shared clock, simultaneous read and write
    fork
      wr_burst(60);
      begin
        rd_set(1'b1, 1'b0, 1'b1);
        repeat (70) @(posedge clk);
        rd_set(1'b0, 1'b1, 1'b0);
      end
    join
    drain();
    settle();
    chk(sb.size() == 0 && rd_flag == 1'b1, "R11 overlapped traffic standard",
        DW'(sb.size()), 0);

    // Fall-through timing, preset offset 16
    do_reset(1'b1, 2'b10);
    rd_set(1'b1, 1'b0, 1'b1);
    repeat (5) @(posedge clk);
    rd_set(1'b0, 1'b1, 1'b0);
    wr_burst(1);
    settle();
    chk(rd_flag == 1'b1, "R6 ready without a read", DW'(rd_flag), 1);
    chk(sb.size() == 1 && rd_data == sb[0], "R6 first word on output", rd_data,
        (sb.size() != 0) ? sb[0] : '0);
    chk(rd_almost_empty == 1'b1, "R9 almost-empty with one word", DW'(rd_almost_empty), 1);
    wr_burst(16);
    settle();
    chk(rd_almost_empty == 1'b0, "R9 almost-empty clear at 17 words", DW'(rd_almost_empty), 0);
    drain();
    settle();
    chk(rd_flag == 1'b0, "R4 not ready after drain", DW'(rd_flag), 0);
    fork
      wr_burst(60);
      begin
        rd_set(1'b1, 1'b0, 1'b1);
        repeat (70) @(posedge clk);
        rd_set(1'b0, 1'b1, 1'b0);
      end
    join
    drain();
    settle();
    chk(sb.size() == 0 && rd_flag == 1'b0, "R11 overlapped traffic fall-through",
        DW'(sb.size()), 0);

    // Standard timing, loaded offsets: empty 5, full 250
    do_reset(1'b0, 2'b00);
    wr_raw(1'b1, 1'b1, 1'b1, 36'd5, 1);
    wr_raw(1'b1, 1'b1, 1'b1, 36'd250, 1);
    settle();
    chk(rd_flag == 1'b1, "R10 offset words not stored", DW'(rd_flag), 1);
    wr_burst(5);
    settle();
    chk(rd_almost_empty == 1'b1, "R10 loaded empty offset at 5 words", DW'(rd_almost_empty), 1);
    chk(wr_almost_full == 1'b0, "R10 loaded full offset at 5 words", DW'(wr_almost_full), 0);
    wr_burst(1);
    settle();
    chk(rd_almost_empty == 1'b0, "R10 loaded empty offset at 6 words", DW'(rd_almost_empty), 0);
    chk(wr_almost_full == 1'b1, "R10 loaded full offset at 6 words", DW'(wr_almost_full), 1);
    drain();
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule